// File: doc/BRIEF.md
# Pseudo-static RAM power and standby sequencer

This block sits on the host side of a pseudo-static RAM and owns two of its control pins: the active-low chip select and the standby-control pin, called `deep_n` here, whose low level requests deep standby. After the supply-good flag rises it runs the power-up sequence. It holds `deep_n` low for a first wait and raises it only while chip select is high. It then holds both pins high for a second, longer wait, and only after that does it grant access by asserting `ready`. All waits are parameters counted in clock cycles.

Once access is granted, the host can request either of two standby levels. Light standby keeps full data retention and releases at once. Deep standby drops `deep_n` low. How it is left depends on the retention code that was programmed when it was entered. With partial retention, a short wake wait is enough. With no retention, the full power-up settle wait must be repeated. Deep standby is only safe once the RAM's mode register has been programmed after power-up. The block tracks this through `mreg_done` and reports it on `mreg_needed`. If deep standby is requested too early, the block refuses it and raises a sticky flag.

States:

- `ST_OFF`: supply not good.
- `ST_PWR_HOLD`: first wait, `deep_n` low.
- `ST_SETTLE`: both pins high.
- `ST_ACTIVE`: access granted.
- `ST_LIGHT`: light standby.
- `ST_DEEP_ENTER`: one cycle with chip select high before `deep_n` falls.
- `ST_DEEP`: deep standby.
- `ST_WAKE`: short wait after partial-retention deep standby.

Transitions:

- `ST_OFF` → `ST_PWR_HOLD` when the supply is good.
- `ST_PWR_HOLD` → `ST_SETTLE` when its wait expires.
- `ST_SETTLE` → `ST_ACTIVE` when its wait expires.
- `ST_ACTIVE` → `ST_DEEP_ENTER` on a granted deep request.
- `ST_ACTIVE` → `ST_LIGHT` on a light request.
- `ST_LIGHT` → `ST_DEEP` on a granted deep request.
- `ST_LIGHT` → `ST_ACTIVE` when the light request is released.
- `ST_DEEP_ENTER` → `ST_DEEP` after one cycle.
- `ST_DEEP` → `ST_WAKE` when the deep request is released with partial retention.
- `ST_DEEP` → `ST_SETTLE` when the deep request is released with no retention.
- `ST_WAKE` → `ST_ACTIVE` when its wait expires.
- Any state → `ST_OFF` when the supply is lost.

Top module: `psram_pwr_seq`

## Requirements
- R1: After reset, or while `supply_ok` is low, the outputs are `cs_n`=1, `deep_n`=0, `ready`=0, `mreg_needed`=1 and `deep_refused`=0.
- R2: Once `supply_ok` is high, `deep_n` stays low for exactly W_POWER cycles. It rises on the (W_POWER+1)-th clock edge after `supply_ok` is first sampled high.
- R3: `cs_n` is high in every cycle in which `deep_n` is low, and in the cycle in which `deep_n` rises.
- R4: During power-up, `cs_n` and `deep_n` both stay high for exactly W_INIT cycles after `deep_n` rises. After that, `cs_n` falls and `ready` rises. `ready` is therefore first seen W_POWER+W_INIT+1 edges after `supply_ok` rises.
- R5: While access is granted, a high `light_req` makes `cs_n`=1, `deep_n`=1 and `ready`=0 on the next edge. Releasing `light_req` restores `cs_n`=0 and `ready`=1 on the following edge.
- R6: A granted `deep_req` raised while access is granted gives one cycle with `cs_n`=1 and `deep_n`=1, then `deep_n`=0. The block stays in deep standby while `deep_req` is held.
- R7: `ret_sel` is sampled on entry to deep standby. For codes 0, 1 and 2 (half, quarter and eighth retention), releasing `deep_req` raises `deep_n` on the next edge with `cs_n` high, and `ready` returns W_WAKE+1 edges after the release.
- R8: For `ret_sel` code 3 (no retention), releasing `deep_req` repeats the settle wait: `ready` returns W_INIT+1 edges after the release, and `cs_n` stays high until then.
- R9: While `mreg_needed`=1, a `deep_req` is refused. Access stays granted, `deep_n` stays high, and `deep_refused` is set on the next edge and stays set. A `mreg_done` pulse clears both `deep_refused` and `mreg_needed` on the next edge.
- R10: Losing `supply_ok` in any state returns all outputs to the R1 values on the next edge, including `mreg_needed`=1. The full power-up timing of R2 and R4 is then repeated.
- R11: When `deep_req` and `light_req` are both high while access is granted, deep standby takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply has reached its minimum level |
| light_req | input | 1 | Level request for light standby |
| deep_req | input | 1 | Level request for deep standby |
| ret_sel | input | 2 | Retention code programmed in the RAM (0 half, 1 quarter, 2 eighth, 3 none) |
| mreg_done | input | 1 | Pulse: the RAM's mode register has been programmed |
| cs_n | output | 1 | Chip select to the RAM, active low |
| deep_n | output | 1 | Standby-control pin to the RAM, low requests deep standby |
| ready | output | 1 | Access to the RAM is granted |
| mreg_needed | output | 1 | Mode register must be programmed before deep standby |
| deep_refused | output | 1 | Sticky: a deep standby request was refused |

## Verification
The bench builds the block with W_POWER=6, W_INIT=10 and W_WAKE=3, instead of the microsecond-scale defaults. With these values, every wait can be counted to the exact edge within a few dozen cycles. Because the three values differ, an exit that takes the wrong wait path shows up as a wrong cycle count. Examples are a no-retention exit that uses the wake wait, or a power-up that swaps the two waits. The small values also let the bench repeat a full power-up after a supply loss and run deep standby with all four retention codes in one short run.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_PWR_HOLD   = 3'd1,
        ST_SETTLE     = 3'd2,
        ST_ACTIVE     = 3'd3,
        ST_LIGHT      = 3'd4,
        ST_DEEP_ENTER = 3'd5,
        ST_DEEP       = 3'd6,
        ST_WAKE       = 3'd7
    } seq_state_t;

    typedef enum logic [1:0] {
        RET_HALF    = 2'd0,
        RET_QUARTER = 2'd1,
        RET_EIGHTH  = 2'd2,
        RET_NONE    = 2'd3
    } ret_code_t;

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // start loads the remaining count; it then counts down to zero and holds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/seq_mreg_guard.sv
module seq_mreg_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mreg_done,
    input  logic deep_try,
    output logic mreg_ok,
    output logic refused
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mreg_ok <= 1'b0;
            refused <= 1'b0;
        end else if (!supply_ok) begin
            // register content is lost with the supply
            mreg_ok <= 1'b0;
            refused <= 1'b0;
        end else if (mreg_done) begin
            mreg_ok <= 1'b1;
            refused <= 1'b0;
        end else if (deep_try && !mreg_ok) begin
            refused <= 1'b1;
        end
    end

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int unsigned W_POWER = 5000,
    parameter int unsigned W_INIT  = 20000,
    parameter int unsigned W_WAKE  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       light_req,
    input  logic       deep_req,
    input  logic [1:0] ret_sel,
    input  logic       mreg_done,
    output logic       cs_n,
    output logic       deep_n,
    output logic       ready,
    output logic       mreg_needed,
    output logic       deep_refused
);

    localparam int unsigned W_MAX_A = (W_POWER > W_INIT) ? W_POWER : W_INIT;
    localparam int unsigned W_MAX   = (W_MAX_A > W_WAKE) ? W_MAX_A : W_WAKE;
    localparam int unsigned CNT_W   = $clog2(W_MAX + 1);

    localparam logic [CNT_W-1:0] LD_POWER = CNT_W'(W_POWER - 1);
    localparam logic [CNT_W-1:0] LD_INIT  = CNT_W'(W_INIT - 1);
    localparam logic [CNT_W-1:0] LD_WAKE  = CNT_W'(W_WAKE - 1);

    seq_state_t       state_q, state_d;
    ret_code_t        ret_q;
    logic             tmr_start, tmr_done;
    logic [CNT_W-1:0] tmr_load;
    logic             mreg_ok, deep_try, deep_ok;

    assign deep_try = deep_req && ((state_q == ST_ACTIVE) || (state_q == ST_LIGHT));
    assign deep_ok  = deep_try && mreg_ok;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:        state_d = ST_PWR_HOLD;
                ST_PWR_HOLD:   if (tmr_done) state_d = ST_SETTLE;
                ST_SETTLE:     if (tmr_done) state_d = ST_ACTIVE;
                ST_ACTIVE: begin
                    if (deep_ok)        state_d = ST_DEEP_ENTER;
                    else if (light_req) state_d = ST_LIGHT;
                end
                ST_LIGHT: begin
                    if (deep_ok)         state_d = ST_DEEP;
                    else if (!light_req) state_d = ST_ACTIVE;
                end
                ST_DEEP_ENTER: state_d = ST_DEEP;
                ST_DEEP: begin
                    if (!deep_req)
                        state_d = (ret_q == RET_NONE) ? ST_SETTLE : ST_WAKE;
                end
                ST_WAKE:       if (tmr_done) state_d = ST_ACTIVE;
            endcase
        end
    end

    // state register and retention capture on entry to deep standby
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            ret_q   <= RET_HALF;
        end else begin
            state_q <= state_d;
            if ((state_d == ST_DEEP) && (state_q != ST_DEEP))
                ret_q <= ret_code_t'(ret_sel);
        end
    end

    // wait length chosen by the state being entered
    always_comb begin
        tmr_start = 1'b0;
        tmr_load  = '0;
        if (supply_ok && (state_d != state_q)) begin
            unique case (state_d)
                ST_PWR_HOLD: begin tmr_start = 1'b1; tmr_load = LD_POWER; end
                ST_SETTLE:   begin tmr_start = 1'b1; tmr_load = LD_INIT;  end
                ST_WAKE:     begin tmr_start = 1'b1; tmr_load = LD_WAKE;  end
                default:     begin tmr_start = 1'b0; tmr_load = '0;       end
            endcase
        end
    end

    seq_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .load    (tmr_load),
        .expired (tmr_done)
    );

    seq_mreg_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .mreg_done (mreg_done),
        .deep_try  (deep_try),
        .mreg_ok   (mreg_ok),
        .refused   (deep_refused)
    );

    // pin levels decoded from the state
    always_comb begin
        cs_n   = 1'b1;
        deep_n = 1'b1;
        ready  = 1'b0;
        unique case (state_q)
            ST_OFF, ST_PWR_HOLD: deep_n = 1'b0;
            ST_DEEP:             deep_n = 1'b0;
            ST_ACTIVE: begin
                cs_n  = 1'b0;
                ready = 1'b1;
            end
            ST_SETTLE, ST_LIGHT, ST_DEEP_ENTER, ST_WAKE: begin
                cs_n   = 1'b1;
                deep_n = 1'b1;
            end
        endcase
    end

    assign mreg_needed = !mreg_ok;

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
    parameter int unsigned W_POWER = 5000,
    parameter int unsigned W_INIT  = 20000,
    parameter int unsigned W_WAKE  = 3
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic deep_req,
    input logic mreg_done,
    input logic cs_n,
    input logic deep_n,
    input logic ready,
    input logic mreg_needed,
    input logic deep_refused
);

    localparam int unsigned CAP_A = (W_POWER > W_INIT) ? W_POWER : W_INIT;
    localparam int unsigned CAP_B = (CAP_A > W_WAKE) ? CAP_A : W_WAKE;
    localparam int unsigned CAP   = CAP_B + 1;
    localparam int unsigned CW    = $clog2(CAP + 1);

    logic [CW-1:0] sup_cnt;   // cycles since supply_ok went high (saturating)
    logic [CW-1:0] hi_cnt;    // cycles since deep_n last rose (saturating)
    logic          cold;      // no access granted since supply was lost
    logic          cs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_cnt <= '0;
            hi_cnt  <= '0;
            cold    <= 1'b1;
            cs_prev <= 1'b1;
        end else begin
            sup_cnt <= !supply_ok ? '0 : ((sup_cnt == CW'(CAP)) ? sup_cnt : sup_cnt + 1'b1);
            hi_cnt  <= !deep_n ? '0 : ((hi_cnt == CW'(CAP)) ? hi_cnt : hi_cnt + 1'b1);
            cs_prev <= cs_n;
            if (!supply_ok)
                cold <= 1'b1;
            else if (cs_prev && !cs_n)
                cold <= 1'b0;
        end
    end

    assert_cs_high_in_deep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !deep_n |-> cs_n);

    assert_cs_high_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deep_n) |-> cs_n);

    assert_power_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deep_n) |-> (sup_cnt > CW'(W_POWER)));

    assert_init_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && cold) |-> (hi_cnt >= CW'(W_INIT)));

    assert_wake_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= CW'(W_WAKE)));

    assert_deep_needs_mreg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(deep_n) && $past(supply_ok)) |-> !mreg_needed);

    assert_refuse_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && deep_req && mreg_needed && !mreg_done && supply_ok) |=> deep_refused);

    assert_power_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (cs_n && !deep_n && !ready && mreg_needed && !deep_refused));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
    .W_POWER (W_POWER),
    .W_INIT  (W_INIT),
    .W_WAKE  (W_WAKE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .deep_req     (deep_req),
    .mreg_done    (mreg_done),
    .cs_n         (cs_n),
    .deep_n       (deep_n),
    .ready        (ready),
    .mreg_needed  (mreg_needed),
    .deep_refused (deep_refused)
);

// File: tb/sim_psram_pwr_seq.sv
`timescale 1ns/1ps
module sim_psram_pwr_seq;

    localparam int W_POWER = 6;
    localparam int W_INIT  = 10;
    localparam int W_WAKE  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       light_req = 1'b0;
    logic       deep_req = 1'b0;
    logic [1:0] ret_sel = 2'd0;
    logic       mreg_done = 1'b0;
    logic       cs_n, deep_n, ready, mreg_needed, deep_refused;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    psram_pwr_seq #(.W_POWER(W_POWER), .W_INIT(W_INIT), .W_WAKE(W_WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .light_req(light_req),
        .deep_req(deep_req), .ret_sel(ret_sel), .mreg_done(mreg_done),
        .cs_n(cs_n), .deep_n(deep_n), .ready(ready),
        .mreg_needed(mreg_needed), .deep_refused(deep_refused)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_pins(input string req, input int c, input int d, input int r);
        check(req, "cs_n", cs_n, c);
        check(req, "deep_n", deep_n, d);
        check(req, "ready", ready, r);
    endtask

    // power-up from supply_ok rising; returns after ready is seen
    task automatic t_powerup(input string req);
        int cyc = 0;
        int rise = 0;
        int bad = 0;
        supply_ok = 1'b1;
        while (!ready && cyc < 1000) begin
            tick();
            cyc++;
            if (deep_n && rise == 0) rise = cyc;
            if (!deep_n && !cs_n) bad++;
            if (!ready && !cs_n) bad++;
        end
        check({req, " R2"}, "edge of deep_n rise", rise, W_POWER + 1);
        check({req, " R4"}, "edges to ready", cyc, W_POWER + W_INIT + 1);
        check({req, " R3"}, "cycles with cs_n low too early", bad, 0);
    endtask

    task automatic t_reset();
        check_pins("R1", 1, 0, 0);
        check("R1", "mreg_needed", mreg_needed, 1);
        check("R1", "deep_refused", deep_refused, 0);
        repeat (3) tick();
        check_pins("R1 supply low", 1, 0, 0);
    endtask

    task automatic t_refuse();
        check("R9", "mreg_needed before programming", mreg_needed, 1);
        deep_req = 1'b1;
        tick();
        check_pins("R9 refused request", 0, 1, 1);
        check("R9", "deep_refused", deep_refused, 1);
        deep_req = 1'b0;
        tick();
        check("R9", "deep_refused sticky", deep_refused, 1);
        mreg_done = 1'b1;
        tick();
        mreg_done = 1'b0;
        check("R9", "mreg_needed after mreg_done", mreg_needed, 0);
        check("R9", "deep_refused after mreg_done", deep_refused, 0);
    endtask

    task automatic t_light();
        light_req = 1'b1;
        tick();
        check_pins("R5 light entry", 1, 1, 0);
        repeat (4) tick();
        check_pins("R5 light held", 1, 1, 0);
        light_req = 1'b0;
        tick();
        check_pins("R5 light exit", 0, 1, 1);
    endtask

    task automatic t_deep(input int code);
        int cyc = 0;
        int exp;
        int bad = 0;
        ret_sel = code[1:0];
        deep_req = 1'b1;
        tick();
        check_pins("R6 enter cycle", 1, 1, 0);
        tick();
        check_pins("R6 deep", 1, 0, 0);
        ret_sel = 2'd0;   // retention code is taken at entry
        repeat (5) tick();
        check_pins("R6 deep held", 1, 0, 0);
        deep_req = 1'b0;
        tick();
        cyc = 1;
        check_pins(code == 3 ? "R8 exit first edge" : "R7 exit first edge", 1, 1, 0);
        while (!ready && cyc < 1000) begin
            tick();
            cyc++;
            if (!ready && !cs_n) bad++;
        end
        exp = (code == 3) ? W_INIT + 1 : W_WAKE + 1;
        check(code == 3 ? "R8" : "R7", "edges from release to ready", cyc, exp);
        check(code == 3 ? "R8" : "R7", "cs_n low before ready", bad, 0);
    endtask

    task automatic t_priority();
        light_req = 1'b1;
        deep_req  = 1'b1;
        ret_sel   = 2'd1;
        tick();
        check_pins("R11 first edge", 1, 1, 0);
        tick();
        check("R11", "deep_n low (deep chosen)", deep_n, 0);
        light_req = 1'b0;
        deep_req  = 1'b0;
        repeat (W_WAKE + 1) tick();
        check("R11", "ready after wake", ready, 1);
    endtask

    task automatic t_supply_loss();
        ret_sel = 2'd2;
        deep_req = 1'b1;
        repeat (3) tick();
        check("R10", "in deep before loss", deep_n, 0);
        supply_ok = 1'b0;
        tick();
        check_pins("R10 after loss", 1, 0, 0);
        check("R10", "mreg_needed", mreg_needed, 1);
        check("R10", "deep_refused", deep_refused, 0);
        deep_req = 1'b0;
        repeat (3) tick();
        check_pins("R10 held off", 1, 0, 0);
        t_powerup("R10 repeat");
        check("R10", "mreg_needed after repeat", mreg_needed, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_powerup("R1 first");
        t_refuse();
        t_light();
        for (int c = 0; c < 4; c++) t_deep(c);
        t_priority();
        t_supply_loss();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule